// File: doc/BRIEF.md
# Serial Byte Deserializer with Word Assembly Queue

This block takes a serial bit stream that arrives on its own clock together with a qualifying enable. On every clock edge where the enable is high it moves one bit into a byte-wide shift register. It also advances a bit position counter. The live contents of the shift register drive an output directly, so neighbouring logic can react to each bit as it arrives, without waiting for a whole byte.

When the counter reaches the last bit position, that same edge completes a byte. The completed byte, including the bit sampled on that edge, is pushed into a small circular queue, and a one-cycle strobe follows. The queue holds four bytes. A consumer may pull bytes out one at a time. When all four slots are filled it may instead take them together as a single 32-bit word, with the earliest byte in the top bits. If the queue is full when a byte completes, the byte is discarded and a sticky error flag is raised.

The byte width and the queue depth are parameters. The word width follows from their product.

Top module: `serial_word_deser`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets `shreg_q`, `bit_idx`, `fifo_level`, `cap_stb`, `word_valid` and `ovf` to zero.
- R2: On a rising edge with `en` high, `shreg_q` becomes `{shreg_q[6:0], sdata}`. The newest bit enters bit 0 and the earlier bits move toward bit 7. `shreg_q` shows the register itself.
- R3: On a rising edge with `en` low, `shreg_q` and `bit_idx` keep their values, whatever `sdata` does.
- R4: `bit_idx` counts enabled edges from 0 up to 7 and wraps back to 0. A value of 0 marks a byte boundary.
- R5: An enabled edge taken while `bit_idx` is 7 pushes `{shreg_q[6:0], sdata}` into the queue on that same edge, so the eighth bit needs no further edge. `cap_stb` is high for exactly the one cycle that follows that edge.
- R6: `rd_byte` shows the oldest queued byte. A `byte_pop` when `fifo_level` is nonzero removes that byte. A `byte_pop` on an empty queue changes nothing.
- R7: `word_valid` is high exactly when `fifo_level` is 4. `word_q` then holds the four queued bytes, with the oldest in bits 31:24 and the newest in bits 7:0.
- R8: A `word_take` while `word_valid` is high empties the queue, and it takes precedence over a `byte_pop` on the same edge. A `word_take` while `word_valid` is low is ignored.
- R9: A byte that completes while `fifo_level` is already 4 is discarded, and the queue contents stay unchanged. `ovf` is then set and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Qualifies the current edge as carrying a bit |
| sdata | input | 1 | Serial data bit |
| byte_pop | input | 1 | Removes the oldest queued byte |
| word_take | input | 1 | Removes all four queued bytes as one word |
| shreg_q | output | 8 | Live shift register contents |
| bit_idx | output | 3 | Bit position within the current byte |
| cap_stb | output | 1 | One-cycle pulse after a byte is captured |
| rd_byte | output | 8 | Oldest queued byte |
| fifo_level | output | 3 | Number of bytes queued (0 to 4) |
| word_valid | output | 1 | Queue holds a full word |
| word_q | output | 32 | Assembled word, earliest byte on top |
| ovf | output | 1 | Sticky flag: a byte was dropped because the queue was full |

## Verification
The hardest situation to reach is a capture that arrives while the queue is full and the read pointer has already moved away from slot 0. In that state both the word ordering across the wrap and the rule that a drop leaves the queue untouched matter at once. The stimulus first pops one byte so the pointers sit at an odd offset. It then serializes four more bytes to fill the queue, and clocks a fifth byte through the serial input to force the drop. After that it checks `word_q`, `fifo_level` and `ovf`. Simultaneous `byte_pop` and `word_take`, and removal requests on an empty or partly filled queue, are driven in the same sequence.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  localparam int unsigned SDW_BYTE_W = 8;
  localparam int unsigned SDW_DEPTH  = 4;

  // width needed to hold the values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sdw_shifter.sv
module sdw_shifter #(
  parameter int unsigned BYTE_W = sdw_pkg::SDW_BYTE_W,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sdata,
  output logic [BYTE_W-1:0] shreg_q,
  output logic [CNT_W-1:0]  bit_idx,
  output logic              cap_vld,
  output logic [BYTE_W-1:0] cap_data,
  output logic              cap_stb
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg_n;

  // value the register takes on this edge; the capture uses it directly
  assign shreg_n  = {shreg_q[BYTE_W-2:0], sdata};
  assign cap_vld  = en && (bit_idx == LAST_IDX);
  assign cap_data = shreg_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      bit_idx <= '0;
      cap_stb <= 1'b0;
    end else begin
      cap_stb <= cap_vld;
      if (en) begin
        shreg_q <= shreg_n;
        bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sdw_word_view.sv
module sdw_word_view #(
  parameter int unsigned BYTE_W = sdw_pkg::SDW_BYTE_W,
  parameter int unsigned DEPTH  = sdw_pkg::SDW_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned WORD_W = BYTE_W * DEPTH
) (
  input  logic [WORD_W-1:0] slots,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [WORD_W-1:0] word_q
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_lane
    localparam logic [PTR_W:0] OFS = (PTR_W+1)'(k);
    logic [PTR_W:0]   sum;
    logic [PTR_W-1:0] idx;
    assign sum = {1'b0, rd_ptr} + OFS;
    assign idx = (sum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(sum - (PTR_W+1)'(DEPTH))
                                            : PTR_W'(sum);
    // lane k holds the k-th oldest byte; oldest sits on top
    assign word_q[(DEPTH-1-k)*BYTE_W +: BYTE_W] = slots[idx*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/sdw_fifo.sv
module sdw_fifo #(
  parameter int unsigned BYTE_W = sdw_pkg::SDW_BYTE_W,
  parameter int unsigned DEPTH  = sdw_pkg::SDW_DEPTH,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned LVL_W  = sdw_pkg::cnt_width(DEPTH),
  localparam int unsigned WORD_W = BYTE_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  input  logic              take,
  output logic [BYTE_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              word_valid,
  output logic              ovf,
  output logic [WORD_W-1:0] word_q
);

  localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level_n;
  logic              push_ok, pop_ok, take_ok;
  logic [WORD_W-1:0] slots;

  assign take_ok = take && (level == FULL_L);
  assign push_ok = push && (level != FULL_L);
  assign pop_ok  = pop && !take_ok && (level != '0);

  always_comb begin
    level_n = level;
    if (take_ok) begin
      level_n = '0;
    end else begin
      if (push_ok) level_n = level_n + LVL_W'(1);
      if (pop_ok)  level_n = level_n - LVL_W'(1);
    end
  end

  // storage without reset so it can map to RAM-style resources
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      level      <= '0;
      word_valid <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      level      <= level_n;
      word_valid <= (level_n == FULL_L);
      if (push && !push_ok) ovf <= 1'b1;
      if (push_ok) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + PTR_W'(1);
      // a full take leaves rd_ptr where it is: it goes once round the ring
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + PTR_W'(1);
    end
  end

  assign head = mem[rd_ptr];

  for (genvar s = 0; s < DEPTH; s++) begin : g_flat
    assign slots[s*BYTE_W +: BYTE_W] = mem[s];
  end

  sdw_word_view #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_view (
    .slots  (slots),
    .rd_ptr (rd_ptr),
    .word_q (word_q)
  );

endmodule

// File: rtl/serial_word_deser.sv
module serial_word_deser #(
  parameter int unsigned BYTE_W = sdw_pkg::SDW_BYTE_W,
  parameter int unsigned DEPTH  = sdw_pkg::SDW_DEPTH,
  localparam int unsigned CNT_W  = $clog2(BYTE_W),
  localparam int unsigned LVL_W  = sdw_pkg::cnt_width(DEPTH),
  localparam int unsigned WORD_W = BYTE_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sdata,
  input  logic              byte_pop,
  input  logic              word_take,
  output logic [BYTE_W-1:0] shreg_q,
  output logic [CNT_W-1:0]  bit_idx,
  output logic              cap_stb,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_q,
  output logic              ovf
);

  logic              cap_vld;
  logic [BYTE_W-1:0] cap_data;

  sdw_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sdata    (sdata),
    .shreg_q  (shreg_q),
    .bit_idx  (bit_idx),
    .cap_vld  (cap_vld),
    .cap_data (cap_data),
    .cap_stb  (cap_stb)
  );

  sdw_fifo #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (cap_vld),
    .push_data  (cap_data),
    .pop        (byte_pop),
    .take       (word_take),
    .head       (rd_byte),
    .level      (fifo_level),
    .word_valid (word_valid),
    .ovf        (ovf),
    .word_q     (word_q)
  );

endmodule

// File: rtl/sdw_checker.sv
module sdw_checker #(
  parameter int unsigned BYTE_W = sdw_pkg::SDW_BYTE_W,
  parameter int unsigned DEPTH  = sdw_pkg::SDW_DEPTH,
  localparam int unsigned CNT_W  = $clog2(BYTE_W),
  localparam int unsigned LVL_W  = sdw_pkg::cnt_width(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              sdata,
  input logic              byte_pop,
  input logic              word_take,
  input logic [BYTE_W-1:0] shreg_q,
  input logic [CNT_W-1:0]  bit_idx,
  input logic              cap_stb,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              word_valid,
  input logic              ovf
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);
  localparam logic [LVL_W-1:0] FULL_L   = LVL_W'(DEPTH);

  logic last_bit;
  assign last_bit = en && (bit_idx == LAST_IDX);

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> shreg_q == {$past(shreg_q[BYTE_W-2:0]), $past(sdata)});

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(shreg_q) && $stable(bit_idx)));

  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> bit_idx == '0);

  // R5
  cap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> cap_stb);

  // R5
  cap_single_chk: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> !cap_stb);

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_level == '0 && byte_pop && !last_bit) |=> fifo_level == '0);

  // R7
  word_flag_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid == (fifo_level == FULL_L));

  // R8
  take_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_take) |=> fifo_level == '0);

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (last_bit && fifo_level == FULL_L) |=> ovf);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= FULL_L);

endmodule

bind serial_word_deser sdw_checker #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .sdata      (sdata),
  .byte_pop   (byte_pop),
  .word_take  (word_take),
  .shreg_q    (shreg_q),
  .bit_idx    (bit_idx),
  .cap_stb    (cap_stb),
  .fifo_level (fifo_level),
  .word_valid (word_valid),
  .ovf        (ovf)
);

// File: tb/test_serial_word_deser.sv
`timescale 1ns/1ps
module test_serial_word_deser;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        sdata = 1'b0;
  logic        byte_pop = 1'b0;
  logic        word_take = 1'b0;
  logic [7:0]  shreg_q;
  logic [2:0]  bit_idx;
  logic        cap_stb;
  logic [7:0]  rd_byte;
  logic [2:0]  fifo_level;
  logic        word_valid;
  logic [31:0] word_q;
  logic        ovf;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  serial_word_deser i_serial_word_deser (
    .clk(clk), .rst(rst), .en(en), .sdata(sdata),
    .byte_pop(byte_pop), .word_take(word_take),
    .shreg_q(shreg_q), .bit_idx(bit_idx), .cap_stb(cap_stb),
    .rd_byte(rd_byte), .fifo_level(fifo_level), .word_valid(word_valid),
    .word_q(word_q), .ovf(ovf)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one bit on one edge; sample just after the edge
  task automatic send_bit(input logic b);
    @(negedge clk); en = 1'b1; sdata = b;
    @(posedge clk); #1; en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic strobe(input logic p, input logic t);
    @(negedge clk); byte_pop = p; word_take = t;
    @(posedge clk); #1; byte_pop = 1'b0; word_take = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1; rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "shreg_q", 32'(shreg_q), 0);
    chk("R1", "bit_idx", 32'(bit_idx), 0);
    chk("R1", "level", 32'(fifo_level), 0);
    chk("R1", "cap_stb", 32'(cap_stb), 0);
    chk("R1", "word_valid", 32'(word_valid), 0);
    chk("R1", "ovf", 32'(ovf), 0);
  endtask

  task automatic t_shift_hold_capture();
    send_bit(1); send_bit(0); send_bit(1);
    chk("R2", "shreg after 101", 32'(shreg_q), 32'h05);
    chk("R4", "bit_idx after 3", 32'(bit_idx), 3);
    // R3: enable low, data toggling
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sdata = i[0];
    end
    @(posedge clk); #1;
    chk("R3", "shreg held", 32'(shreg_q), 32'h05);
    chk("R3", "bit_idx held", 32'(bit_idx), 3);
    send_bit(1); send_bit(1); send_bit(0); send_bit(0);
    chk("R5", "no strobe before 8th", 32'(cap_stb), 0);
    send_bit(1);
    chk("R2", "shreg full byte", 32'(shreg_q), 32'hB9);
    chk("R4", "bit_idx wrap", 32'(bit_idx), 0);
    chk("R5", "cap_stb after 8th", 32'(cap_stb), 1);
    chk("R5", "level 1", 32'(fifo_level), 1);
    chk("R5", "captured incl. last bit", 32'(rd_byte), 32'hB9);
    @(posedge clk); #1;
    chk("R5", "cap_stb one cycle", 32'(cap_stb), 0);
  endtask

  task automatic t_pop_and_word();
    strobe(1, 0);
    chk("R6", "pop to empty", 32'(fifo_level), 0);
    strobe(1, 0);
    chk("R6", "pop on empty ignored", 32'(fifo_level), 0);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    chk("R6", "head oldest", 32'(rd_byte), 32'h11);
    chk("R7", "no word at 3", 32'(word_valid), 0);
    strobe(0, 1);
    chk("R8", "take ignored at 3", 32'(fifo_level), 3);
    send_byte(8'h44);
    chk("R7", "word_valid at 4", 32'(word_valid), 1);
    chk("R7", "word order over wrap", word_q, 32'h11223344);
    chk("R9", "ovf clear before drop", 32'(ovf), 0);
    send_byte(8'h55);
    chk("R9", "ovf set on drop", 32'(ovf), 1);
    chk("R9", "level stays full", 32'(fifo_level), 4);
    chk("R9", "word unchanged", word_q, 32'h11223344);
    strobe(1, 1);
    chk("R8", "take wins over pop", 32'(fifo_level), 0);
    chk("R8", "word_valid cleared", 32'(word_valid), 0);
    chk("R9", "ovf sticky", 32'(ovf), 1);
    send_byte(8'hA5); send_byte(8'h3C);
    chk("R6", "head after take", 32'(rd_byte), 32'hA5);
    strobe(1, 0);
    chk("R6", "head after pop", 32'(rd_byte), 32'h3C);
    chk("R6", "level after pop", 32'(fifo_level), 1);
    do_reset();
    chk("R1", "ovf cleared by reset", 32'(ovf), 0);
    chk("R1", "level cleared by reset", 32'(fifo_level), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_shift_hold_capture();
    t_pop_and_word();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule